// File: doc/BRIEF.md
# Packet Timestamp Capture Registers

This block latches the running 64-bit time value when a transmit or a receive packet event is reported. The packet datapath raises a one-cycle event strobe together with a qualify flag, which says whether that packet is one to be timestamped. Two identical capture units, one for transmit and one for receive, each keep one captured value. That value waits until software collects it through a small register interface.

A unit holds one outstanding capture. Once it has a value, it refuses further events until software has read the high capture word. The stored value therefore always belongs to the one packet that produced it. Events that are refused, because the unit is disabled or already full, are counted in a saturating counter. Each capture also sets a cause bit. The interrupt output is raised when any cause bit is set together with its mask bit.

Software reads the low word first and the high word second. Reading the low word has no side effect. Reading the high word releases the unit.

Top module: `pkt_tstamp_capture`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `irq` is 0.
- R2: An enabled unit without a held value captures on a strobe with qualify set. It stores `time_now` from that same cycle and sets its valid bit. The low word (transmit address 1, receive address 4) returns bits 31:0 of the stored value, and the high word (transmit address 2, receive address 5) returns bits 63:32.
- R3: A strobe with qualify clear has no effect: it causes no capture and is not counted.
- R4: While valid is set, qualified strobes are refused and the stored value does not change.
- R5: A read of the high word clears valid. A read of the low word alone leaves valid set, and the unit keeps refusing events.
- R6: The enable bit of a unit is bit 0 of its control register (transmit address 0, receive address 3). A write sets this bit, and it reads back. While it is 0, qualified strobes are refused. Once it is set again, capturing resumes.
- R7: A refused qualified strobe increments an 8-bit counter held in control bits 15:8. The counter saturates at 255. Valid is control bit 1 and is read-only.
- R8: A capture sets a cause bit at address 6: bit 0 for transmit, bit 1 for receive. Writing 1 to a cause bit clears it. `irq` is high when any cause bit is set and its mask bit at address 7 (same bit order, read/write) is also set.
- R9: The transmit and receive units are independent: an event, read or write aimed at one does not change the state of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_evt | input | 1 | Transmit packet event strobe |
| tx_qual | input | 1 | Transmit event is to be timestamped |
| rx_evt | input | 1 | Receive packet event strobe |
| rx_qual | input | 1 | Receive event is to be timestamped |
| time_now | input | 64 | Current time from the timer |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (read side effects apply at the clock edge) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt output |

## Verification
On every cycle, the assertions check four things: a capture stores the time of its own cycle, a held value stays frozen, valid clears only on a high-word read, and a disabled empty unit stays empty. They also check that the miss counter holds at saturation and that a cause bit only rises after a capture. The bench scenarios are needed to show the register-level behaviour: low-then-high read ordering, that an unqualified strobe is ignored, that re-enabling resumes capturing, and write-1-to-clear combined with masking. They also show that the two units stay independent over a long mixed random sequence, checked against a reference model.

// File: rtl/ts_cap_pkg.sv
// Package: register addresses and control-word field positions shared by
// the capture block and its submodules. Assumes a 3-bit word address.
package ts_cap_pkg;
    localparam int ADDR_W      = 3;
    localparam int NUM_UNITS   = 2;
    localparam int REGS_PER_U  = 3;
    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_VL_BIT = 1;
    localparam int CTRL_MS_LSB = 8;
    localparam logic [ADDR_W-1:0] ADDR_CAUSE = 3'd6;
    localparam logic [ADDR_W-1:0] ADDR_MASK  = 3'd7;
endpackage

// File: rtl/ts_capture_unit.sv
// Capture unit: holds one timestamp taken on a qualified event strobe.
// Assumes the event strobe is one cycle per packet. It refuses events while
// disabled or while a value is held. A high-word read releases the held value.
module ts_capture_unit #(
    parameter int TIME_W = 64,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic              qual_i,
    input  logic [TIME_W-1:0] time_i,
    input  logic              en_wr_i,
    input  logic              en_wdata_i,
    input  logic              hi_rd_i,
    output logic              en_o,
    output logic              valid_o,
    output logic [TIME_W-1:0] stamp_o,
    output logic [CNT_W-1:0]  missed_o,
    output logic              cap_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic              en_q;
    logic              valid_q;
    logic [TIME_W-1:0] stamp_q;
    logic [CNT_W-1:0]  missed_q;
    logic              take;
    logic              cap;
    logic              drop;

    // Classify the incoming strobe as a capture or a refused event.
    always_comb begin
        take = evt_i & qual_i;
        cap  = take & en_q & ~valid_q;
        drop = take & ~cap;
    end

    // Enable bit, valid flag and stored time value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            valid_q <= 1'b0;
            stamp_q <= '0;
        end else begin
            if (en_wr_i) en_q <= en_wdata_i;
            if (cap) begin
                valid_q <= 1'b1;
                stamp_q <= time_i;
            end else if (hi_rd_i) begin
                valid_q <= 1'b0;
            end
        end
    end

    // Saturating count of refused qualified events.
    always_ff @(posedge clk) begin
        if (!rst_n)                          missed_q <= '0;
        else if (drop && missed_q != CNT_MAX) missed_q <= missed_q + 1'b1;
    end

    assign en_o     = en_q;
    assign valid_o  = valid_q;
    assign stamp_o  = stamp_q;
    assign missed_o = missed_q;
    assign cap_o    = cap;

    AST_CAPTURE_SAMPLES_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && qual_i && en_q && !valid_q) |=> (valid_q && stamp_q == $past(time_i))); // R2
    AST_STAMP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> $stable(stamp_q)); // R4
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !hi_rd_i) |=> valid_q); // R5
    AST_DISABLED_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !valid_q) |=> !valid_q); // R6
    AST_MISS_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_q == CNT_MAX) |=> (missed_q == CNT_MAX)); // R7
endmodule

// File: rtl/ts_irq_ctrl.sv
// Interrupt control: one sticky cause bit per unit, set by a capture pulse,
// write-1-to-clear, and gated by a mask register. A set beats a clear that
// arrives in the same cycle.
module ts_irq_ctrl #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cap_i,
    input  logic         cause_wr_i,
    input  logic         mask_wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] cause_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);
    logic [N-1:0] cause_q;
    logic [N-1:0] mask_q;

    for (genvar i = 0; i < N; i++) begin : g_cause
        // Sticky cause bit with write-1-to-clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                         cause_q[i] <= 1'b0;
            else if (cap_i[i])                  cause_q[i] <= 1'b1;
            else if (cause_wr_i && wdata_i[i])  cause_q[i] <= 1'b0;
        end

        AST_CAUSE_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            (!cause_q[i] && !cap_i[i]) |=> !cause_q[i]); // R8
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_wr_i) mask_q <= wdata_i;
    end

    assign cause_o = cause_q;
    assign mask_o  = mask_q;
    assign irq_o   = |(cause_q & mask_q);
endmodule

// File: rtl/pkt_tstamp_capture.sv
// Top: a transmit and a receive capture unit, an interrupt controller, and
// the register decode. Reads are combinational. Side effects of a read (high
// word releases the unit) and of a write take effect at the clock edge.
// Assumes TIME_W is twice WORD_W and that the counter fits in the control word.
module pkt_tstamp_capture
    import ts_cap_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_evt,
    input  logic              tx_qual,
    input  logic              rx_evt,
    input  logic              rx_qual,
    input  logic [TIME_W-1:0] time_now,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int NU = NUM_UNITS;

    logic [NU-1:0]             evt_v;
    logic [NU-1:0]             qual_v;
    logic [NU-1:0]             u_en;
    logic [NU-1:0]             u_valid;
    logic [NU-1:0]             u_cap;
    logic [NU-1:0][TIME_W-1:0] u_stamp;
    logic [NU-1:0][CNT_W-1:0]  u_miss;
    logic [NU-1:0]             cause;
    logic [NU-1:0]             mask;
    logic                      unused_wdata;

    assign evt_v        = {rx_evt, tx_evt};
    assign qual_v       = {rx_qual, tx_qual};
    assign unused_wdata = ^reg_wdata[WORD_W-1:NU];

    for (genvar u = 0; u < NU; u++) begin : g_unit
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REGS_PER_U * u);
        localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(REGS_PER_U * u + 2);

        ts_capture_unit #(.TIME_W(TIME_W), .CNT_W(CNT_W)) unit_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (evt_v[u]),
            .qual_i     (qual_v[u]),
            .time_i     (time_now),
            .en_wr_i    (reg_wr_en && reg_addr == A_CTRL),
            .en_wdata_i (reg_wdata[CTRL_EN_BIT]),
            .hi_rd_i    (reg_rd_en && reg_addr == A_HI),
            .en_o       (u_en[u]),
            .valid_o    (u_valid[u]),
            .stamp_o    (u_stamp[u]),
            .missed_o   (u_miss[u]),
            .cap_o      (u_cap[u])
        );
    end

    ts_irq_ctrl #(.N(NU)) irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (u_cap),
        .cause_wr_i (reg_wr_en && reg_addr == ADDR_CAUSE),
        .mask_wr_i  (reg_wr_en && reg_addr == ADDR_MASK),
        .wdata_i    (reg_wdata[NU-1:0]),
        .cause_o    (cause),
        .mask_o     (mask),
        .irq_o      (irq)
    );

    // Read data select over unit registers, cause and mask.
    always_comb begin
        reg_rdata = '0;
        for (int u = 0; u < NU; u++) begin
            if (reg_addr == ADDR_W'(REGS_PER_U * u)) begin
                reg_rdata[CTRL_EN_BIT]            = u_en[u];
                reg_rdata[CTRL_VL_BIT]            = u_valid[u];
                reg_rdata[CTRL_MS_LSB +: CNT_W]   = u_miss[u];
            end
            if (reg_addr == ADDR_W'(REGS_PER_U * u + 1))
                reg_rdata = u_stamp[u][WORD_W-1:0];
            if (reg_addr == ADDR_W'(REGS_PER_U * u + 2))
                reg_rdata = u_stamp[u][TIME_W-1:WORD_W];
        end
        if (reg_addr == ADDR_CAUSE) reg_rdata[NU-1:0] = cause;
        if (reg_addr == ADDR_MASK)  reg_rdata[NU-1:0] = mask;
    end

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq); // R8
endmodule

// File: tb/pkt_tstamp_capture_tb_top.sv
`timescale 1ns/1ps
module pkt_tstamp_capture_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_evt = 0, tx_qual = 0, rx_evt = 0, rx_qual = 0;
    logic [63:0] time_now = '0;
    logic        reg_wr_en = 0, reg_rd_en = 0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference model
    bit          m_en[2];
    bit          m_val[2];
    logic [63:0] m_stamp[2];
    int          m_miss[2];
    logic [1:0]  m_cause = 0;
    logic [1:0]  m_mask = 0;

    always #2.5 clk = ~clk;

    pkt_tstamp_capture dut_i (
        .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .tx_qual(tx_qual),
        .rx_evt(rx_evt), .rx_qual(rx_qual), .time_now(time_now),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_reg(input logic [2:0] a);
        int u;
        u = (a < 3) ? 0 : 1;
        case (a)
            3'd0, 3'd3: exp_reg = {16'd0, 8'(m_miss[u]), 6'd0, m_val[u], m_en[u]};
            3'd1, 3'd4: exp_reg = m_stamp[u][31:0];
            3'd2, 3'd5: exp_reg = m_stamp[u][63:32];
            3'd6:       exp_reg = {30'd0, m_cause};
            default:    exp_reg = {30'd0, m_mask};
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [2:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        e = exp_reg(a);
        reg_rd_en = 1; reg_addr = a;
        #1 check(tag, reg_rdata, e);
        @(negedge clk);
        reg_rd_en = 0;
        if (a == 3'd2) m_val[0] = 0;
        if (a == 3'd5) m_val[1] = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0;
        case (a)
            3'd0: m_en[0] = d[0];
            3'd3: m_en[1] = d[0];
            3'd6: m_cause = m_cause & ~d[1:0];
            3'd7: m_mask = d[1:0];
            default: ;
        endcase
    endtask

    task automatic ev(input int u, input bit q, input logic [63:0] t);
        @(negedge clk);
        time_now = t;
        if (u == 0) begin tx_evt = 1; tx_qual = q; end
        else        begin rx_evt = 1; rx_qual = q; end
        @(negedge clk);
        tx_evt = 0; tx_qual = 0; rx_evt = 0; rx_qual = 0;
        time_now = '0;
        if (q) begin
            if (m_en[u] && !m_val[u]) begin
                m_val[u] = 1; m_stamp[u] = t; m_cause[u] = 1'b1;
            end else if (m_miss[u] < 255) m_miss[u]++;
        end
    endtask

    task automatic irq_chk(input string tag);
        @(negedge clk);
        check(tag, irq, |(m_cause & m_mask));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int u = 0; u < 2; u++) begin
            m_en[u] = 0; m_val[u] = 0; m_stamp[u] = 0; m_miss[u] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 8; a++) rd_chk(3'(a), "R1 reset regs");
        irq_chk("R1 reset irq");
        // R3 unqualified strobe
        wr(3'd0, 32'h1);
        ev(0, 0, 64'h1111_2222_3333_4444);
        rd_chk(3'd0, "R3 unqualified ignored");
        // R2 capture
        ev(0, 1, 64'hDEAD_BEEF_0123_4567);
        rd_chk(3'd0, "R2 valid set");
        rd_chk(3'd6, "R8 tx cause set");
        irq_chk("R8 masked irq low");
        // R4 refused while valid
        ev(0, 1, 64'hAAAA_BBBB_CCCC_DDDD);
        rd_chk(3'd1, "R4 low word kept");
        // R5 low read does not release
        ev(0, 1, 64'h5555_6666_7777_8888);
        rd_chk(3'd0, "R5 still valid after low read");
        rd_chk(3'd2, "R2 high word");
        rd_chk(3'd0, "R5 high read releases");
        // R8 mask and W1C
        wr(3'd7, 32'h1);
        irq_chk("R8 irq raised");
        wr(3'd6, 32'h1);
        irq_chk("R8 w1c clears irq");
        rd_chk(3'd6, "R8 cause cleared");
        // R6 disable / re-enable
        wr(3'd0, 32'h0);
        ev(0, 1, 64'h0102_0304_0506_0708);
        rd_chk(3'd0, "R6 disabled refuses");
        wr(3'd0, 32'h1);
        ev(0, 1, 64'h0A0B_0C0D_0E0F_1011);
        rd_chk(3'd0, "R6 re-enabled captures");
        rd_chk(3'd1, "R6 low word");
        // R9 rx independent
        wr(3'd3, 32'h1);
        ev(1, 1, 64'hFEDC_BA98_7654_3210);
        rd_chk(3'd3, "R9 rx ctrl");
        rd_chk(3'd5, "R9 rx high");
        rd_chk(3'd0, "R9 tx untouched");
        rd_chk(3'd2, "R9 tx high");
        // R7 saturation
        wr(3'd3, 32'h0);
        for (int i = 0; i < 300; i++) ev(1, 1, 64'(i));
        rd_chk(3'd3, "R7 counter saturates");
        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0, 1: ev(int'($urandom % 2), ($urandom % 10) < 7, {$urandom, $urandom});
                2: rd_chk(3'($urandom % 8), "R9 random read");
                3: wr(($urandom % 2) ? 3'd3 : 3'd0, {31'd0, ($urandom % 4) != 0});
                4: wr(3'd6, 32'($urandom % 4));
                default: wr(3'd7, 32'($urandom % 4));
            endcase
            irq_chk("R8 random irq");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule